// File: doc/BRIEF.md
# Piecewise-Linear Spread-Spectrum Deviation Generator

This block produces the digital frequency-deviation word that steers a fractional feedback divider in a spread-spectrum clock source. A single accumulator, clocked by the reference clock, adds or subtracts a per-cycle step. A segment sequencer chooses that step. One modulation period is made of six straight-line segments. The three rising segments use the steep step, then the gentle step, then the steep step again. The three falling segments mirror them. Because the slope is steeper next to both extremes than in the middle, the spectrum spreads more evenly than it does with a plain triangle.

The block spreads downward only. The word is an unsigned amount by which the clock frequency is lowered. It starts each period at zero and climbs towards the programmed full scale. The two step sizes, the two segment lengths and the full-scale limit come from input pins. The block copies them into shadow registers only while it is idle or when a period wraps. A change made mid-period therefore never bends the current waveform. Saturation at zero and at full scale keeps an inconsistent set of settings from wrapping the word.

Top module: `pwl_profile_gen`

## Requirements
- R1: After reset, `dev_o` is 0 and `seg_o` is 0. Code 0 means idle.
- R2: When `en` is sampled low at a clock edge, `dev_o` and `seg_o` are 0 after that edge. When `en` is first sampled high from idle, `seg_o` becomes 1 and `dev_o` stays 0.
- R3: Segments run in the order 1,2,3,4,5,6,1,… and are shown on `seg_o` as those codes. In each cycle of segment 1 or 3, `slope_steep` is added. In segment 2, `slope_gentle` is added. In segment 4 or 6, `slope_steep` is subtracted. In segment 5, `slope_gentle` is subtracted.
- R4: Segments 1, 3, 4 and 6 each last `len_edge` cycles. Segments 2 and 5 each last `len_mid` cycles. A period is therefore 4·`len_edge` + 2·`len_mid` cycles.
- R5: A length value of 0 is treated as a one-cycle segment.
- R6: An addition never takes `dev_o` above the captured `full_scale`. A sum that is too large is clamped to `full_scale`.
- R7: A subtraction never takes `dev_o` below 0. A step larger than the current value gives 0.
- R8: The five settings are captured only while the block is idle (or `en` is low) and at the edge where segment 6 ends. A change at any other time first takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulation enable; low forces zero deviation |
| slope_steep | input | W_SLOPE | Step used next to the extremes (segments 1,3,4,6) |
| slope_gentle | input | W_SLOPE | Step used in the middle (segments 2,5) |
| len_edge | input | W_LEN | Cycles per steep segment |
| len_mid | input | W_LEN | Cycles per gentle segment |
| full_scale | input | W_DEV | Largest allowed deviation |
| dev_o | output | W_DEV | Downward frequency-deviation word |
| seg_o | output | 3 | Current segment code (0 idle, 1..6) |

## Verification
The bench predicts every cycle of whole periods from the settings. A design that picked the wrong slope for a segment, or that miscounted a segment length by one, would drift from the prediction within a few cycles. The bench programs a full scale below the natural peak so that the rising edge clamps. The step size then overshoots zero on the way down. A design without clamping would wrap to a huge deviation or fall short of the limit. Zero-length segments, settings changed in the middle of a period, and a disable in the middle of a segment are also covered. Wrong handling shows up as a segment that vanishes, a waveform whose slope changes mid-period, or a word that is not zero after disable.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    typedef enum logic [2:0] {
        SEG_IDLE   = 3'd0,
        SEG_RISE_A = 3'd1,
        SEG_RISE_B = 3'd2,
        SEG_RISE_C = 3'd3,
        SEG_FALL_A = 3'd4,
        SEG_FALL_B = 3'd5,
        SEG_FALL_C = 3'd6
    } seg_e;

    function automatic seg_e next_seg(input seg_e s);
        case (s)
            SEG_IDLE:   next_seg = SEG_RISE_A;
            SEG_RISE_A: next_seg = SEG_RISE_B;
            SEG_RISE_B: next_seg = SEG_RISE_C;
            SEG_RISE_C: next_seg = SEG_FALL_A;
            SEG_FALL_A: next_seg = SEG_FALL_B;
            SEG_FALL_B: next_seg = SEG_FALL_C;
            default:    next_seg = SEG_RISE_A;
        endcase
    endfunction

    function automatic logic seg_rising(input seg_e s);
        seg_rising = (s == SEG_RISE_A) || (s == SEG_RISE_B) || (s == SEG_RISE_C);
    endfunction

    function automatic logic seg_falling(input seg_e s);
        seg_falling = (s == SEG_FALL_A) || (s == SEG_FALL_B) || (s == SEG_FALL_C);
    endfunction

    function automatic logic seg_is_mid(input seg_e s);
        seg_is_mid = (s == SEG_RISE_B) || (s == SEG_FALL_B);
    endfunction

endpackage

// File: rtl/pwl_cfg_shadow.sv
module pwl_cfg_shadow #(
    parameter int W_SLOPE = 8,
    parameter int W_LEN   = 12,
    parameter int W_DEV   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [W_SLOPE-1:0] steep_i,
    input  logic [W_SLOPE-1:0] gentle_i,
    input  logic [W_LEN-1:0]   len_edge_i,
    input  logic [W_LEN-1:0]   len_mid_i,
    input  logic [W_DEV-1:0]   fs_i,
    output logic [W_SLOPE-1:0] steep_o,
    output logic [W_SLOPE-1:0] gentle_o,
    output logic [W_LEN-1:0]   len_edge_o,
    output logic [W_LEN-1:0]   len_mid_o,
    output logic [W_DEV-1:0]   fs_o
);

    typedef struct packed {
        logic [W_SLOPE-1:0] steep;
        logic [W_SLOPE-1:0] gentle;
        logic [W_LEN-1:0]   len_edge;
        logic [W_LEN-1:0]   len_mid;
        logic [W_DEV-1:0]   fs;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.steep    = steep_i;
            cfg_d.gentle   = gentle_i;
            cfg_d.len_edge = len_edge_i;
            cfg_d.len_mid  = len_mid_i;
            cfg_d.fs       = fs_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign steep_o    = cfg_q.steep;
    assign gentle_o   = cfg_q.gentle;
    assign len_edge_o = cfg_q.len_edge;
    assign len_mid_o  = cfg_q.len_mid;
    assign fs_o       = cfg_q.fs;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/pwl_seg_seq.sv
module pwl_seg_seq #(
    parameter int W_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [W_LEN-1:0]  len_edge_i,
    input  logic [W_LEN-1:0]  len_mid_i,
    output pwl_pkg::seg_e     seg_o,
    output logic              load_o
);
    import pwl_pkg::*;

    typedef struct packed {
        seg_e             seg;
        logic [W_LEN-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic [W_LEN-1:0] cur_len;
    logic             last_cyc;

    always_comb begin
        cur_len  = seg_is_mid(st_q.seg) ? len_mid_i : len_edge_i;
        last_cyc = ({1'b0, st_q.cnt} + (W_LEN+1)'(1)) >= {1'b0, cur_len};

        st_d   = st_q;
        load_o = 1'b0;
        if (!en_i) begin
            st_d.seg = SEG_IDLE;
            st_d.cnt = '0;
            load_o   = 1'b1;
        end else if (st_q.seg == SEG_IDLE) begin
            st_d.seg = SEG_RISE_A;
            st_d.cnt = '0;
            load_o   = 1'b1;
        end else if (last_cyc) begin
            st_d.seg = next_seg(st_q.seg);
            st_d.cnt = '0;
            load_o   = (st_q.seg == SEG_FALL_C);
        end else begin
            st_d.cnt = st_q.cnt + W_LEN'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seg: SEG_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign seg_o = st_q.seg;

    // R3
    seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.seg != SEG_IDLE) |=>
            (st_q.seg == $past(st_q.seg)) || (st_q.seg == next_seg($past(st_q.seg))));

    // R3
    seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seg <= SEG_FALL_C);

    // R2
    seg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.seg == SEG_IDLE) |=> st_q.seg == SEG_RISE_A);

endmodule

// File: rtl/pwl_accum.sv
module pwl_accum #(
    parameter int W_DEV   = 16,
    parameter int W_SLOPE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  pwl_pkg::seg_e      seg_i,
    input  logic [W_SLOPE-1:0] steep_i,
    input  logic [W_SLOPE-1:0] gentle_i,
    input  logic [W_DEV-1:0]   limit_i,
    output logic [W_DEV-1:0]   dev_o
);
    import pwl_pkg::*;

    localparam int W_SUM = W_DEV + 1;

    typedef struct packed {
        logic [W_DEV-1:0] dev;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [W_SUM-1:0] step_x;
    logic [W_SUM-1:0] sum_x;

    always_comb begin
        step_x = W_SUM'(seg_is_mid(seg_i) ? gentle_i : steep_i);
        sum_x  = {1'b0, acc_q.dev} + step_x;
        acc_d  = acc_q;
        if (!en_i || seg_i == SEG_IDLE) begin
            acc_d.dev = '0;
        end else if (seg_rising(seg_i)) begin
            if (sum_x > {1'b0, limit_i}) acc_d.dev = limit_i;
            else                         acc_d.dev = sum_x[W_DEV-1:0];
        end else if (seg_falling(seg_i)) begin
            if ({1'b0, acc_q.dev} < step_x) acc_d.dev = '0;
            else                            acc_d.dev = acc_q.dev - step_x[W_DEV-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign dev_o = acc_q.dev;

    // R6
    top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && seg_rising(seg_i)) |=> acc_q.dev <= $past(limit_i));

    // R7
    fall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && seg_falling(seg_i)) |=> acc_q.dev <= $past(acc_q.dev));

    // R3
    rise_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && seg_rising(seg_i) && acc_q.dev <= limit_i) |=> acc_q.dev >= $past(acc_q.dev));

endmodule

// File: rtl/pwl_profile_gen.sv
module pwl_profile_gen #(
    parameter int W_DEV   = 16,
    parameter int W_SLOPE = 8,
    parameter int W_LEN   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [W_SLOPE-1:0] slope_steep,
    input  logic [W_SLOPE-1:0] slope_gentle,
    input  logic [W_LEN-1:0]   len_edge,
    input  logic [W_LEN-1:0]   len_mid,
    input  logic [W_DEV-1:0]   full_scale,
    output logic [W_DEV-1:0]   dev_o,
    output logic [2:0]         seg_o
);
    import pwl_pkg::*;

    logic               load_w;
    logic [W_SLOPE-1:0] steep_w, gentle_w;
    logic [W_LEN-1:0]   len_edge_w, len_mid_w;
    logic [W_DEV-1:0]   fs_w;
    seg_e               seg_w;

    pwl_cfg_shadow #(.W_SLOPE(W_SLOPE), .W_LEN(W_LEN), .W_DEV(W_DEV)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .steep_i    (slope_steep),
        .gentle_i   (slope_gentle),
        .len_edge_i (len_edge),
        .len_mid_i  (len_mid),
        .fs_i       (full_scale),
        .steep_o    (steep_w),
        .gentle_o   (gentle_w),
        .len_edge_o (len_edge_w),
        .len_mid_o  (len_mid_w),
        .fs_o       (fs_w)
    );

    pwl_seg_seq #(.W_LEN(W_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .len_edge_i (len_edge_w),
        .len_mid_i  (len_mid_w),
        .seg_o      (seg_w),
        .load_o     (load_w)
    );

    pwl_accum #(.W_DEV(W_DEV), .W_SLOPE(W_SLOPE)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .seg_i    (seg_w),
        .steep_i  (steep_w),
        .gentle_i (gentle_w),
        .limit_i  (fs_w),
        .dev_o    (dev_o)
    );

    assign seg_o = seg_w;

    // R2
    disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dev_o == '0) && (seg_o == 3'd0));

endmodule

// File: tb/pwl_profile_gen_bench.sv
module pwl_profile_gen_bench;

    localparam int W_DEV = 16, W_SLOPE = 8, W_LEN = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [W_SLOPE-1:0] slope_steep = '0, slope_gentle = '0;
    logic [W_LEN-1:0]   len_edge = '0, len_mid = '0;
    logic [W_DEV-1:0]   full_scale = '0;
    logic [W_DEV-1:0]   dev_o;
    logic [2:0]         seg_o;

    int checks = 0;
    int errors = 0;
    int exp_dev = 0;

    always #5 clk = ~clk;

    pwl_profile_gen #(.W_DEV(W_DEV), .W_SLOPE(W_SLOPE), .W_LEN(W_LEN)) u_pwl_profile_gen (
        .clk(clk), .rst_n(rst_n), .en(en),
        .slope_steep(slope_steep), .slope_gentle(slope_gentle),
        .len_edge(len_edge), .len_mid(len_mid), .full_scale(full_scale),
        .dev_o(dev_o), .seg_o(seg_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input int a1, input int a2, input int t1, input int t2, input int fs);
        slope_steep  = W_SLOPE'(a1);
        slope_gentle = W_SLOPE'(a2);
        len_edge     = W_LEN'(t1);
        len_mid      = W_LEN'(t2);
        full_scale   = W_DEV'(fs);
    endtask

    // Leaves the bench at a falling edge with seg_o == 1 and dev_o == 0.
    task automatic start_run(input int a1, input int a2, input int t1, input int t2, input int fs);
        en = 1'b0;
        drive(a1, a2, t1, t2, fs);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        exp_dev = 0;
        chk("R2 start seg", int'(seg_o), 1);
        chk("R2 start dev", int'(dev_o), 0);
    endtask

    // Predicts one period from the settings in force; optionally changes pins at segment 2.
    task automatic run_period(input int a1, input int a2, input int t1, input int t2, input int fs,
                              input bit chg, input int n1, input int n2, input int nt1, input int nt2,
                              input int nfs);
        for (int s = 1; s <= 6; s++) begin
            int len = (s == 2 || s == 5) ? t2 : t1;
            int step = (s == 2 || s == 5) ? a2 : a1;
            if (len == 0) len = 1; // R5
            for (int k = 0; k < len; k++) begin
                if (chg && s == 2 && k == 0) drive(n1, n2, nt1, nt2, nfs);
                chk("R3 R4 segment", int'(seg_o), s);
                chk("R3 R6 R7 deviation", int'(dev_o), exp_dev);
                if (s <= 3) exp_dev = (exp_dev + step > fs) ? fs : exp_dev + step;
                else        exp_dev = (exp_dev < step) ? 0 : exp_dev - step;
                @(negedge clk);
            end
        end
        chk("R4 wrap to segment 1", int'(seg_o), 1);
    endtask

    task automatic t_reset();
        chk("R1 reset dev", int'(dev_o), 0);
        chk("R1 reset seg", int'(seg_o), 0);
    endtask

    task automatic t_basic();
        start_run(10, 3, 4, 6, 1000);
        run_period(10, 3, 4, 6, 1000, 1'b0, 0, 0, 0, 0, 0);
        chk("R3 period ends at zero", int'(dev_o), 0);
        run_period(10, 3, 4, 6, 1000, 1'b0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_peak();
        int peak = 0;
        start_run(20, 2, 3, 5, 5000);
        repeat (2 * 3 + 5) @(negedge clk);
        peak = int'(dev_o);
        chk("R3 peak value 2*3*20+5*2", peak, 130);
        chk("R4 falling starts after 11 cycles", int'(seg_o), 4);
    endtask

    task automatic t_saturate();
        start_run(10, 3, 4, 6, 50);
        run_period(10, 3, 4, 6, 50, 1'b0, 0, 0, 0, 0, 0);
        start_run(40, 1, 2, 3, 65000);
        run_period(40, 1, 2, 3, 65000, 1'b0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_zero_len();
        start_run(5, 7, 0, 2, 1000);
        run_period(5, 7, 0, 2, 1000, 1'b0, 0, 0, 0, 0, 0);
        start_run(9, 4, 3, 0, 1000);
        run_period(9, 4, 3, 0, 1000, 1'b0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_cfg_mid();
        start_run(10, 3, 4, 6, 1000);
        run_period(10, 3, 4, 6, 1000, 1'b1, 30, 1, 2, 3, 1000);
        run_period(30, 1, 2, 3, 1000, 1'b0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_disable();
        start_run(10, 3, 4, 6, 1000);
        repeat (6) @(negedge clk);
        chk("R2 mid-profile nonzero", (dev_o != 0) ? 1 : 0, 1);
        en = 1'b0;
        @(negedge clk);
        chk("R2 disabled dev", int'(dev_o), 0);
        chk("R2 disabled seg", int'(seg_o), 0);
        drive(8, 8, 2, 2, 1000);
        repeat (3) @(negedge clk);
        chk("R2 held dev", int'(dev_o), 0);
        chk("R2 held seg", int'(seg_o), 0);
        en = 1'b1;
        @(negedge clk);
        exp_dev = 0;
        chk("R2 restart seg", int'(seg_o), 1);
        run_period(8, 8, 2, 2, 1000, 1'b0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_peak();
        t_saturate();
        t_zero_len();
        t_cfg_mid();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule